// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a 16-bit register interface. Software writes a control register and a service register through a synchronous single-cycle port. The control register sets the timeout, arms the counter, chooses which suspend conditions apply, and carries two active-low bits that force the internal reset request or the external reset output directly.

Once armed, the counter steps down on each pulse of a 2 Hz tick enable. Software keeps the system alive by writing a two-word key pair to the service register. If the count runs out first, the block raises both reset outputs for a fixed pulse and latches a sticky status flag. The counter then reloads and keeps counting.

The arm bit cannot be cleared by software. Writing the same control value again has no side effect, so a driver may repeat a write to make sure it lands.

Top module: `wdg_timer`

## Requirements
- R1: After reset the control register reads 0x0018, `sys_rst_req` is 0, `ext_rst_n` is 1 and `tmo_flag` is 0.
- R2: With `reg_sel`=0 the control register is addressed, and with `reg_sel`=1 the service register is addressed. The control layout is: bits [15:8] timeout field, bit 0 arm, bit 1 debug-suspend, bit 2 low-power-suspend, bit 3 internal-reset-off (active low), bit 4 external-reset-off (active low). Bits [7:5] read 0, and the service register reads 0.
- R3: Once the arm bit is 1, a control write with bit 0 = 0 leaves it at 1 until reset.
- R4: Arming with timeout field N causes expiry on the (N+1)th tick that counts after the arming write.
- R5: A service write of 0x5555 followed by a service write of 0xAAAA reloads the counter with the current timeout field.
- R6: A service write of any other value between the two keys cancels the pair, and a 0xAAAA with no 0x5555 before it reloads nothing.
- R7: A rewrite of the timeout field while armed does not change the running count; the new value applies from the next reload.
- R8: Writing bit 3 = 0 raises `sys_rst_req` from the cycle after the write, and writing it back to 1 releases it.
- R9: Writing bit 4 = 0 drives `ext_rst_n` low from the cycle after the write, and writing it back to 1 releases it.
- R10: With debug-suspend set, ticks are ignored while `dbg_halt` is 1.
- R11: With low-power-suspend set, ticks are ignored while `lp_mode` is 1.
- R12: On expiry, `sys_rst_req` is 1 and `ext_rst_n` is 0 for exactly 16 cycles. `tmo_flag` goes to 1 and stays there until reset. The counter reloads from the field and keeps counting.
- R13: Writing an unchanged control value again, any number of times while armed, does not reload or otherwise disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects service |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| tick_2hz | input | 1 | One-cycle count enable at 2 Hz |
| dbg_halt | input | 1 | Debug halt indication |
| lp_mode | input | 1 | Low-power mode indication |
| sys_rst_req | output | 1 | Internal reset request, active high |
| ext_rst_n | output | 1 | External reset output, active low |
| tmo_flag | output | 1 | Sticky expiry status |

## Verification
The bench builds the block with its default parameters: an 8-bit timeout field and a 16-cycle expiry pulse. The bench drives the tick input directly, one pulse per few clocks, so small fields such as 2 and 5 reach expiry in tens of cycles. This makes key ordering, suspend gating, field rewrites and back-to-back expiries all reachable in a short run. The full pulse is observed cycle by cycle against the reference model. The largest field value is not run to expiry.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int REG_W = 16;
    localparam int TMO_W = 8;
    localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_SVC  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic [2:0]       rsvd;
        logic             ext_off_n;
        logic             int_off_n;
        logic             lp_susp;
        logic             dbg_susp;
        logic             arm;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{tmo: '0, rsvd: '0, ext_off_n: 1'b1,
                                   int_off_n: 1'b1, lp_susp: 1'b0,
                                   dbg_susp: 1'b0, arm: 1'b0};

    function automatic ctrl_t ctrl_merge(ctrl_t cur, logic [REG_W-1:0] d);
        ctrl_t n;
        n.tmo       = d[15:8];
        n.rsvd      = '0;
        n.ext_off_n = d[4];
        n.int_off_n = d[3];
        n.lp_susp   = d[2];
        n.dbg_susp  = d[1];
        n.arm       = cur.arm | d[0];
        return n;
    endfunction
endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic             arm_rise
);
    assign arm_rise = wr && !ctrl_q.arm && wdata[0];

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= CTRL_RST;
        else if (wr) ctrl_q <= ctrl_merge(ctrl_q, wdata);
    end

    a_r3_arm_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.arm |=> ctrl_q.arm);
endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic             reload
);
    logic armed_q;

    assign reload = wr && armed_q && (wdata == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst)     armed_q <= 1'b0;
        else if (wr) armed_q <= (wdata == KEY_ARM);
    end

    // R5/R6: a completed pair consumes the arming
    a_r6_pair_consumed: assert property (@(posedge clk) disable iff (rst)
        reload |=> !armed_q);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int TMO_W     = 8,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    output logic             fire,
    output logic             pulse_on,
    output logic             flag
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [TMO_W-1:0] cnt_q;
    logic [PW-1:0]    pcnt_q;
    logic             step;

    assign step     = tick && run && !load;
    assign fire     = step && (cnt_q == '0);
    assign pulse_on = (pcnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pcnt_q <= '0;
            flag   <= 1'b0;
        end else begin
            if (load)      cnt_q <= load_val;
            else if (fire) cnt_q <= load_val;
            else if (step) cnt_q <= cnt_q - 1'b1;

            if (fire)          pcnt_q <= PW'(PULSE_LEN);
            else if (pulse_on) pcnt_q <= pcnt_q - 1'b1;

            if (fire) flag <= 1'b1;
        end
    end

    always_comb begin
        a_r12_pulse_bound: assert (rst || pcnt_q <= PW'(PULSE_LEN));
    end

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!load && !(tick && run)) |=> $stable(cnt_q));

    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        tick_2hz,
    input  logic        dbg_halt,
    input  logic        lp_mode,
    output logic        sys_rst_req,
    output logic        ext_rst_n,
    output logic        tmo_flag
);
    ctrl_t            ctrl_q;
    logic             arm_rise, key_reload, fire, pulse_on, run, ctrl_wr, svc_wr;
    logic [TMO_W-1:0] load_val;

    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
    assign svc_wr  = reg_wr && (reg_sel == SEL_SVC);

    wdg_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(reg_wdata),
        .ctrl_q(ctrl_q), .arm_rise(arm_rise)
    );

    wdg_key_seq u_key (
        .clk(clk), .rst(rst), .wr(svc_wr), .wdata(reg_wdata),
        .reload(key_reload)
    );

    assign run = ctrl_q.arm
               && !(ctrl_q.dbg_susp && dbg_halt)
               && !(ctrl_q.lp_susp  && lp_mode);

    // arming takes the field being written, everything else the stored field
    assign load_val = arm_rise ? reg_wdata[15:8] : ctrl_q.tmo;

    wdg_countdown #(.TMO_W(TMO_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_2hz), .run(run),
        .load(arm_rise || key_reload), .load_val(load_val),
        .fire(fire), .pulse_on(pulse_on), .flag(tmo_flag)
    );

    assign sys_rst_req = !ctrl_q.int_off_n || pulse_on;
    assign ext_rst_n   = ctrl_q.ext_off_n && !pulse_on;
    assign reg_rdata   = (reg_sel == SEL_SVC) ? '0 : ctrl_q;

    a_r12_fire_outputs: assert property (@(posedge clk) disable iff (rst)
        fire |=> (sys_rst_req && !ext_rst_n && tmo_flag));
endmodule

// File: tb/wdg_timer_test.sv
module wdg_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1, reg_wr = 0, reg_sel = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        tick_2hz = 0, dbg_halt = 0, lp_mode = 0;
    logic        sys_rst_req, ext_rst_n, tmo_flag;

    int total = 0, bad = 0;
    string phase = "R1";

    // reference model state
    int m_tmo, m_en, m_dbg, m_lp, m_int, m_ext, m_cnt, m_armed, m_pulse, m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_timer uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_2hz(tick_2hz),
        .dbg_halt(dbg_halt), .lp_mode(lp_mode), .sys_rst_req(sys_rst_req),
        .ext_rst_n(ext_rst_n), .tmo_flag(tmo_flag)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_tmo = 0; m_en = 0; m_dbg = 0; m_lp = 0; m_int = 1; m_ext = 1;
            m_cnt = 0; m_armed = 0; m_pulse = 0; m_flag = 0;
        end else begin
            bit ld, fire, run;
            int ldv;
            ld = 0; fire = 0; ldv = 0;
            run = m_en != 0 && !(m_dbg != 0 && dbg_halt) && !(m_lp != 0 && lp_mode);
            if (reg_wr && !reg_sel && m_en == 0 && reg_wdata[0]) begin
                ld = 1; ldv = int'(reg_wdata[15:8]);
            end
            if (reg_wr && reg_sel) begin
                if (reg_wdata == 16'hAAAA && m_armed != 0) begin ld = 1; ldv = m_tmo; end
                m_armed = (reg_wdata == 16'h5555) ? 1 : 0;
            end
            if (ld) m_cnt = ldv;
            else if (tick_2hz && run) begin
                if (m_cnt == 0) begin fire = 1; m_cnt = m_tmo; end
                else m_cnt = m_cnt - 1;
            end
            if (fire) m_pulse = 16;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (fire) m_flag = 1;
            if (reg_wr && !reg_sel) begin
                m_tmo = int'(reg_wdata[15:8]);
                m_en  = m_en | int'(reg_wdata[0]);
                m_dbg = int'(reg_wdata[1]); m_lp = int'(reg_wdata[2]);
                m_int = int'(reg_wdata[3]); m_ext = int'(reg_wdata[4]);
            end
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, tagged by the current phase
    always @(negedge clk) begin
        if (!rst) begin
            logic [15:0] exp_rd;
            exp_rd = reg_sel ? 16'h0 :
                {m_tmo[7:0], 3'b000, m_ext[0], m_int[0], m_lp[0], m_dbg[0], m_en[0]};
            check({phase, " rdata"}, reg_rdata, exp_rd);
            check({phase, " sys_rst_req"}, {15'd0, sys_rst_req},
                  {15'd0, (m_int == 0) || (m_pulse > 0)});
            check({phase, " ext_rst_n"}, {15'd0, ext_rst_n},
                  {15'd0, (m_ext != 0) && (m_pulse == 0)});
            check({phase, " tmo_flag"}, {15'd0, tmo_flag}, {15'd0, m_flag != 0});
        end
    end

    task automatic wr_reg(logic sel, logic [15:0] d);
        @(posedge clk); #1 reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0; reg_sel = 0;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 tick_2hz = 1;
            @(posedge clk); #1 tick_2hz = 0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3); rst = 0; idle(2);
        phase = "R1";
        @(negedge clk);
        check("R1 ctrl reset", reg_rdata, 16'h0018);
        check("R1 flag reset", {15'd0, tmo_flag}, 16'd0);

        phase = "R2";
        wr_reg(0, 16'h03FE);
        @(negedge clk); check("R2 layout", reg_rdata, 16'h031E);
        #1 reg_sel = 1; @(negedge clk); check("R2 service reads 0", reg_rdata, 16'h0);
        #1 reg_sel = 0;
        wr_reg(0, 16'h0018);

        phase = "R8";
        wr_reg(0, 16'h0010);
        @(negedge clk); check("R8 int reset on", {15'd0, sys_rst_req}, 16'd1);
        wr_reg(0, 16'h0018);
        @(negedge clk); check("R8 int reset off", {15'd0, sys_rst_req}, 16'd0);

        phase = "R9";
        wr_reg(0, 16'h0008);
        @(negedge clk); check("R9 ext reset on", {15'd0, ext_rst_n}, 16'd0);
        wr_reg(0, 16'h0018);

        phase = "R4";
        wr_reg(0, 16'h0219);
        tick(2);
        @(negedge clk); check("R4 no expiry after 2 ticks", {15'd0, tmo_flag}, 16'd0);
        tick(1);
        @(negedge clk); check("R4 expiry on 3rd tick", {15'd0, tmo_flag}, 16'd1);

        phase = "R12";
        begin
            int hi = 0;
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                if (sys_rst_req && !ext_rst_n) hi++;
            end
            check("R12 pulse length", 16'(hi + 1), 16'd16);
        end

        phase = "R3";
        wr_reg(0, 16'h0218);
        @(negedge clk); check("R3 arm sticky", reg_rdata, 16'h0219);

        phase = "R5";
        tick(1); wr_reg(1, 16'h5555); wr_reg(1, 16'hAAAA);
        tick(2); idle(2); tick(1); idle(20);

        phase = "R6";
        tick(1); wr_reg(1, 16'h5555); wr_reg(1, 16'h1234); wr_reg(1, 16'hAAAA);
        tick(2); idle(20);
        wr_reg(1, 16'hAAAA); tick(3); idle(20);

        phase = "R7";
        tick(1); wr_reg(0, 16'h0519); tick(2); idle(20);
        wr_reg(1, 16'h5555); wr_reg(1, 16'hAAAA); tick(5); idle(3); tick(1); idle(20);

        phase = "R13";
        tick(2);
        repeat (3) wr_reg(0, 16'h0519);
        tick(4); idle(20);

        phase = "R10";
        wr_reg(0, 16'h031B); wr_reg(1, 16'h5555); wr_reg(1, 16'hAAAA);
        #1 dbg_halt = 1; tick(6); idle(2);
        @(negedge clk); check("R10 held by debug", {15'd0, sys_rst_req}, 16'd0);
        #1 dbg_halt = 0; tick(4); idle(20);

        phase = "R11";
        wr_reg(0, 16'h031D); wr_reg(1, 16'h5555); wr_reg(1, 16'hAAAA);
        #1 lp_mode = 1; tick(6); idle(2);
        @(negedge clk); check("R11 held by low power", {15'd0, sys_rst_req}, 16'd0);
        #1 dbg_halt = 1; lp_mode = 0; tick(4); idle(20);
        #1 dbg_halt = 0;

        phase = "R1";
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule